// File: doc/BRIEF.md
# Multi-Channel Programmable Interval Timer

This block holds six down-counting timers that share one memory-mapped register window with 32-bit data. Each channel picks one of four externally generated tick-enable inputs, divides it by two raised to a programmable exponent, and decrements its counter once per divided tick. A channel either reloads from its interval value and keeps going (periodic) or halts after a single expiry (one-shot). Every expiry raises that channel's sticky status bit. Software clears status by writing ones. A per-channel mask gates the status bit onto that channel's own interrupt line.

Each channel is run by a two-state machine. CH_IDLE means stopped, with the counter holding its value. CH_RUN means counting. There are three transitions. START goes from CH_IDLE to CH_RUN on a control write with the enable bit set. HALT goes from CH_RUN to CH_IDLE on a control write with the enable bit clear. EXPIRE_STOP goes from CH_RUN to CH_IDLE when a one-shot channel expires. Periodic expiry stays in CH_RUN. The enable bit read back from a control register is the state itself, so a one-shot expiry shows up as a cleared enable bit.

The window covers 1 KB of byte address (10 bits). The irq-mask register sits at 0x000 and the irq-status register at 0x004. Channel n (0..5) occupies 0x010*(n+1), with control at +0x0, interval at +0x4 and live count at +0x8. The channel is address bits [7:4] minus one, and bits [9:8] must be zero. Read data is registered: a read presented at a clock edge appears on `bus_rdata` after that edge and holds until the next read.

Top module: `ivl_timer_bank`

## Requirements
- R1: After reset every register reads zero: the irq mask, the irq status, and each channel's control, interval and count. Every channel is in CH_IDLE and `irq` is all zero.
- R2: Registers decode as stated above. The control register reads back bits [7:0], where bit 0 is enable, bit 1 is reload, [3:2] is the source select, [6:4] is the prescale exponent and bit 7 is one-shot; bits [31:8] read zero. The interval register holds all 32 bits. Any other offset, a channel slot outside 1..6, and any address with bits [9:8] non-zero reads zero, and writes to it have no effect.
- R3: A control write with bit 1 set loads the channel counter from its interval register.
- R4: In CH_RUN the counter drops by one on each divided tick. In CH_IDLE it holds its value, whatever the tick inputs do.
- R5: The channel counts only ticks from input `src_tick[sel]`, where sel is control [3:2]. A divided tick occurs on every 2^n-th selected tick, where n is control [6:4]. A control write restarts the prescale count.
- R6: On a divided tick with the counter at 1 or 0, the channel expires. A periodic channel (bit 7 = 0) reloads from the interval, sets its status bit and stays in CH_RUN.
- R7: On expiry, a one-shot channel (bit 7 = 1) sets its counter to 0 and its status bit, then takes EXPIRE_STOP. Its enable bit then reads 0, and later ticks neither count nor set status.
- R8: A write to irq status clears the bits written as one and leaves the bits written as zero. An expiry in the same cycle as a clear of its bit leaves the bit set.
- R9: The irq mask holds 6 bits, one per channel; bits [31:6] read zero. `irq[i]` is high exactly when status bit i and mask bit i are both set.
- R10: Writes to a count register are ignored. The count register always returns the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Tick-enable pulses of the four count sources |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
The bench targets the expiry boundary. It checks that a periodic channel fires on the tick that finds the counter at 1 and comes back to the interval value; a design that fired at zero would be one tick late and would show 0 where the interval is expected. It checks that a one-shot expiry clears the enable bit and that later ticks leave both the counter and the status untouched; a design that kept running would wrap or raise status again. It also drives an expiry in the same cycle as a write-one-to-clear of that bit, where a design that let the clear win would lose the interrupt. Finally it probes prescale and source selection by counting ticks just below and at the divide ratio, and it probes aliasing addresses, where a loose decoder would return a channel's contents.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int CTL_W       = 8;
    localparam int CTL_EN      = 0;
    localparam int CTL_RLD     = 1;
    localparam int CTL_SRC_LO  = 2;
    localparam int CTL_PRE_LO  = 4;
    localparam int CTL_ONESHOT = 7;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_IVAL = 4'h4;
    localparam logic [3:0] OFS_CNT  = 4'h8;

    localparam logic [7:0] ADR_IRQ_MASK = 8'h00;
    localparam logic [7:0] ADR_IRQ_STAT = 8'h04;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_CTRL,
        RK_IVAL,
        RK_CNT
    } reg_kind_e;

endpackage

// File: rtl/ivl_addr_decode.sv
module ivl_addr_decode
    import ivl_timer_pkg::*;
#(
    parameter int N_CH = 6,
    parameter int AW   = 10
) (
    input  logic [AW-1:0]   addr,
    output logic            hit_mask,
    output logic            hit_stat,
    output logic [N_CH-1:0] ch_sel,
    output reg_kind_e       kind
);

    logic       upper_zero;
    logic [3:0] slot;

    always_comb begin
        upper_zero = (addr[AW-1:8] == '0);
        slot       = addr[7:4];
        hit_mask   = upper_zero && (addr[7:0] == ADR_IRQ_MASK);
        hit_stat   = upper_zero && (addr[7:0] == ADR_IRQ_STAT);
        case (addr[3:0])
            OFS_CTRL: kind = RK_CTRL;
            OFS_IVAL: kind = RK_IVAL;
            OFS_CNT:  kind = RK_CNT;
            default:  kind = RK_NONE;
        endcase
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_sel
        assign ch_sel[g] = upper_zero && (slot == 4'(g + 1)) && (kind != RK_NONE);
    end

endmodule

// File: rtl/ivl_chan.sv
module ivl_chan
    import ivl_timer_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SRC_W = 2,
    parameter int PRE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [(1<<SRC_W)-1:0] src_tick,
    input  logic                 ctrl_wr,
    input  logic                 ival_wr,
    input  logic [CTL_W-1:0]     ctrl_wdata,
    input  logic [DW-1:0]        ival_wdata,
    output logic [CTL_W-1:0]     ctrl_rd,
    output logic [DW-1:0]        ival_rd,
    output logic [DW-1:0]        count_rd,
    output logic                 expire
);

    localparam int PCW = (1 << PRE_W) - 1;

    ch_state_e            state_q, state_d;
    logic [CTL_W-1:1]     ctl_q;
    logic [DW-1:0]        ival_q;
    logic [DW-1:0]        cnt_q, cnt_d;
    logic [PCW-1:0]       pre_q, pre_d;
    logic [PCW-1:0]       pre_mask;
    logic [SRC_W-1:0]     src_sel;
    logic [PRE_W-1:0]     pre_exp;
    logic                 running, sel_tick, div_tick, at_end, oneshot;

    always_comb begin
        src_sel  = ctl_q[CTL_SRC_LO +: SRC_W];
        pre_exp  = ctl_q[CTL_PRE_LO +: PRE_W];
        oneshot  = ctl_q[CTL_ONESHOT];
        pre_mask = PCW'((32'd1 << pre_exp) - 32'd1);
        running  = (state_q == CH_RUN);
        sel_tick = src_tick[src_sel];
        div_tick = running && sel_tick && (pre_q == pre_mask);
        at_end   = (cnt_q <= DW'(1));
        expire   = div_tick && at_end && !ctrl_wr;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state: START, HALT, EXPIRE_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (ctrl_wr && ctrl_wdata[CTL_EN]) state_d = CH_RUN;
            CH_RUN: begin
                if (ctrl_wr && !ctrl_wdata[CTL_EN]) state_d = CH_IDLE;
                else if (expire && oneshot)         state_d = CH_IDLE;
            end
        endcase
    end

    // counter and prescaler outputs
    always_comb begin
        cnt_d = cnt_q;
        pre_d = pre_q;
        if (ctrl_wr) begin
            pre_d = '0;
            if (ctrl_wdata[CTL_RLD]) cnt_d = ival_q;
        end else begin
            if (running && sel_tick)
                pre_d = (pre_q == pre_mask) ? '0 : pre_q + 1'b1;
            if (div_tick)
                cnt_d = at_end ? (oneshot ? '0 : ival_q) : cnt_q - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            ival_q <= '0;
            cnt_q  <= '0;
            pre_q  <= '0;
        end else begin
            if (ctrl_wr) ctl_q  <= ctrl_wdata[CTL_W-1:1];
            if (ival_wr) ival_q <= ival_wdata;
            cnt_q <= cnt_d;
            pre_q <= pre_d;
        end
    end

    assign ctrl_rd  = {ctl_q, running};
    assign ival_rd  = ival_q;
    assign count_rd = cnt_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !ctrl_wr) |=> (cnt_q == $past(cnt_q))); // R4
    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && !at_end && !ctrl_wr) |=> (cnt_q == $past(cnt_q) - DW'(1))); // R4
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CTL_RLD]) |=> (cnt_q == $past(ival_q))); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !oneshot) |=> (cnt_q == $past(ival_q) && state_q == CH_RUN)); // R6
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && oneshot) |=> (state_q == CH_IDLE && cnt_q == '0)); // R7

endmodule

// File: rtl/ivl_irq_bank.sv
module ivl_irq_bank #(
    parameter int N_CH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_wr,
    input  logic            stat_wr,
    input  logic [N_CH-1:0] wdata,
    input  logic [N_CH-1:0] set,
    output logic [N_CH-1:0] mask_rd,
    output logic [N_CH-1:0] stat_rd,
    output logic [N_CH-1:0] irq
);

    logic [N_CH-1:0] mask_q, stat_q, clr;

    assign clr = stat_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (mask_wr) mask_q <= wdata;
            stat_q <= (stat_q & ~clr) | set;
        end
    end

    assign mask_rd = mask_q;
    assign stat_rd = stat_q;
    assign irq     = stat_q & mask_q;

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && set == '0) |=> (stat_q == ($past(stat_q) & ~$past(wdata)))); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((stat_q & $past(set)) == $past(set))); // R8
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wdata))); // R9

endmodule

// File: rtl/ivl_timer_bank.sv
module ivl_timer_bank
    import ivl_timer_pkg::*;
#(
    parameter int N_CH  = 6,
    parameter int DW    = 32,
    parameter int AW    = 10,
    parameter int SRC_W = 2,
    parameter int PRE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SRC_W)-1:0] src_tick,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output logic [N_CH-1:0]       irq
);

    logic            hit_mask, hit_stat;
    logic [N_CH-1:0] ch_sel, ch_expire, mask_rd, stat_rd;
    reg_kind_e       kind;
    logic [CTL_W-1:0] ctrl_a [N_CH];
    logic [DW-1:0]   ival_a [N_CH];
    logic [DW-1:0]   cnt_a  [N_CH];
    logic [DW-1:0]   rd_val;

    ivl_addr_decode #(.N_CH(N_CH), .AW(AW)) u_dec (
        .addr     (bus_addr),
        .hit_mask (hit_mask),
        .hit_stat (hit_stat),
        .ch_sel   (ch_sel),
        .kind     (kind)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        ivl_chan #(.DW(DW), .SRC_W(SRC_W), .PRE_W(PRE_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_tick   (src_tick),
            .ctrl_wr    (bus_wr && ch_sel[g] && kind == RK_CTRL),
            .ival_wr    (bus_wr && ch_sel[g] && kind == RK_IVAL),
            .ctrl_wdata (bus_wdata[CTL_W-1:0]),
            .ival_wdata (bus_wdata),
            .ctrl_rd    (ctrl_a[g]),
            .ival_rd    (ival_a[g]),
            .count_rd   (cnt_a[g]),
            .expire     (ch_expire[g])
        );
    end

    ivl_irq_bank #(.N_CH(N_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (bus_wr && hit_mask),
        .stat_wr (bus_wr && hit_stat),
        .wdata   (bus_wdata[N_CH-1:0]),
        .set     (ch_expire),
        .mask_rd (mask_rd),
        .stat_rd (stat_rd),
        .irq     (irq)
    );

    always_comb begin
        rd_val = '0;
        if (hit_mask) rd_val = DW'(mask_rd);
        if (hit_stat) rd_val = DW'(stat_rd);
        for (int i = 0; i < N_CH; i++) begin
            if (ch_sel[i]) begin
                case (kind)
                    RK_CTRL: rd_val = DW'(ctrl_a[i]);
                    RK_IVAL: rd_val = ival_a[i];
                    RK_CNT:  rd_val = cnt_a[i];
                    default: rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

endmodule

// File: tb/ivl_timer_bank_tb.sv
`timescale 1ns/1ps
module ivl_timer_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ivl_timer_bank u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        rd;
        logic [9:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 10'h000, 32'h0},
        '{1'b1, 10'h004, 32'h0},
        '{1'b1, 10'h010, 32'h0},
        '{1'b1, 10'h014, 32'h0},
        '{1'b1, 10'h018, 32'h0},
        '{1'b1, 10'h068, 32'h0},
        '{1'b0, 10'h014, 32'hDEADBEEF},
        '{1'b1, 10'h014, 32'hDEADBEEF},
        '{1'b0, 10'h064, 32'h12345678},
        '{1'b1, 10'h064, 32'h12345678},
        '{1'b0, 10'h070, 32'hFFFFFFFF},
        '{1'b1, 10'h070, 32'h0},
        '{1'b0, 10'h01C, 32'h0000ABCD},
        '{1'b1, 10'h01C, 32'h0},
        '{1'b0, 10'h020, 32'hFFFFFF7C},
        '{1'b1, 10'h020, 32'h0000007C},
        '{1'b0, 10'h000, 32'hFFFFFFFF},
        '{1'b1, 10'h000, 32'h0000003F},
        '{1'b0, 10'h048, 32'h00000005},
        '{1'b1, 10'h048, 32'h0},
        '{1'b0, 10'h000, 32'h0},
        '{1'b1, 10'h114, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_tick = m;
        end
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 32'(irq), 32'h0);

        // table of register accesses: R1 reset values, R2 decode, R9 mask width, R10 count write
        for (int v = 0; v < NV; v++) begin
            if (VEC[v].rd) begin
                bus_read(VEC[v].addr, r);
                check($sformatf("R1/R2/R9/R10 vector %0d", v), r, VEC[v].data);
            end else begin
                bus_write(VEC[v].addr, VEC[v].data);
            end
        end

        // periodic channel 0, interval 3, source 0, divide 1
        bus_write(10'h014, 32'd3);
        bus_write(10'h010, 32'h03);
        bus_read(10'h018, r);  check("R3 reload loads count", r, 32'd3);
        pulse(4'b0001, 1);
        bus_read(10'h018, r);  check("R4 decrement", r, 32'd2);
        pulse(4'b0001, 1);
        bus_read(10'h004, r);  check("R6 no early expiry", r, 32'h0);
        pulse(4'b0001, 1);
        bus_read(10'h018, r);  check("R6 periodic reload", r, 32'd3);
        bus_read(10'h004, r);  check("R6 status set", r, 32'h1);
        bus_read(10'h010, r);  check("R6 still enabled", r, 32'h03);
        check("R9 masked irq low", 32'(irq), 32'h0);
        bus_write(10'h000, 32'h1);
        @(negedge clk);
        check("R9 irq follows status and mask", 32'(irq), 32'h1);
        bus_write(10'h004, 32'h0);
        bus_read(10'h004, r);  check("R8 zero write keeps status", r, 32'h1);
        bus_write(10'h004, 32'h1);
        bus_read(10'h004, r);  check("R8 one write clears", r, 32'h0);
        check("R9 irq drops after clear", 32'(irq), 32'h0);

        // stop channel 0: counter holds
        bus_write(10'h010, 32'h00);
        pulse(4'b0001, 4);
        bus_read(10'h018, r);  check("R4 idle holds", r, 32'd3);

        // channel 2: source 2, divide by 4, interval 100
        bus_write(10'h034, 32'd100);
        bus_write(10'h030, 32'h2B);
        pulse(4'b1011, 5);
        bus_read(10'h038, r);  check("R5 other sources ignored", r, 32'd100);
        pulse(4'b0100, 3);
        bus_read(10'h038, r);  check("R5 below divide ratio", r, 32'd100);
        pulse(4'b0100, 1);
        bus_read(10'h038, r);  check("R5 at divide ratio", r, 32'd99);
        pulse(4'b0100, 8);
        bus_read(10'h038, r);  check("R5 two more divided ticks", r, 32'd97);

        // channel 4 one-shot, interval 2
        bus_write(10'h054, 32'd2);
        bus_write(10'h050, 32'h83);
        pulse(4'b0001, 2);
        bus_read(10'h058, r);  check("R7 one-shot count zero", r, 32'd0);
        bus_read(10'h050, r);  check("R7 enable cleared", r, 32'h82);
        bus_read(10'h004, r);  check("R7 status set", r, 32'h10);
        bus_write(10'h004, 32'h10);
        pulse(4'b0001, 3);
        bus_read(10'h004, r);  check("R7 no status after stop", r, 32'h0);
        bus_read(10'h058, r);  check("R7 count stays zero", r, 32'd0);

        // channel 5: expiry and clear in the same cycle
        bus_write(10'h000, 32'h3F);
        bus_write(10'h064, 32'd1);
        bus_write(10'h060, 32'h03);
        @(negedge clk);
        src_tick = 4'b0001; bus_wr = 1'b1; bus_addr = 10'h004; bus_wdata = 32'h20;
        @(negedge clk);
        src_tick = '0; bus_wr = 1'b0;
        bus_read(10'h004, r);  check("R8 set wins over clear", r, 32'h20);
        check("R9 irq channel 5", 32'(irq), 32'h20);
        bus_write(10'h004, 32'h20);
        bus_read(10'h004, r);  check("R8 clear alone", r, 32'h0);

        // reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_read(10'h038, r);  check("R1 count cleared", r, 32'h0);
        bus_read(10'h064, r);  check("R1 interval cleared", r, 32'h0);
        bus_read(10'h030, r);  check("R1 channel stopped", r, 32'h0);
        bus_read(10'h000, r);  check("R1 mask cleared", r, 32'h0);
        check("R1 irq low", 32'(irq), 32'h0);

        summary();
        $finish;
    end

endmodule